// File: doc/BRIEF.md
# Reflected CRC-32 folding engine

This block computes a reflected (LSB-first) CRC-32 over the generator 0x04C11DB7 from a stream of 128-bit beats. It does not shift the message through a bit-serial register or a byte lookup table. Instead it keeps a 128-bit running remainder and, on every accepted beat, folds that remainder forward by 16 bytes. Each 64-bit half is carry-less multiplied by its own precomputed constant, and both products are XORed into the new block. The last beat may carry fewer than 16 bytes. In that case the remainder is shifted so that the short block lines up with the message end before the fold.

Once the last beat is in, a three-step sequence brings the remainder down to 32 bits. The first step goes from 128 to 96 bits, the second from 96 to 64 bits, and a Barrett step then produces the final word. The caller supplies the seed on the first beat. Any pre- or post-inversion is the caller's job, and every message must be at least 16 bytes long.

Top module: `crc32r_fold`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1, `crc_done` is 0 and `crc_out` is 0.
- R2: `crc_out` equals the LSB-first CRC-32 of the message. That CRC uses the reversed polynomial 0xEDB88320, starts from `seed`, and applies no inversion. Byte k of a beat sits on `in_data[8k+7:8k]`, byte 0 comes first in the message, and within each byte bit 0 comes first.
- R3: Every beat that is not the last carries 16 message bytes, and `in_bytes` has no effect on those beats.
- R4: On the last beat, `in_bytes` gives the number of valid bytes, which occupy the lowest lanes. The value 0 means 16. Bytes above that count have no effect on the result.
- R5: After the edge that accepts a beat with `in_last` high, `in_ready` is low for exactly three cycles.
- R6: `crc_done` is high for exactly one cycle, which is the cycle in which `in_ready` returns. `crc_out` holds its value until the next `crc_done`.
- R7: Cycles where `in_valid` is low change neither the remainder nor the result.
- R8: `seed` is sampled only on the first beat of a message, and its value on later beats has no effect.
- R9: The first beat of the next message can be accepted in the same cycle that `crc_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed | input | 32 | Starting CRC value, taken on the first beat |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Engine can take a beat |
| in_data | input | 128 | Sixteen message bytes, earliest byte in the low lane |
| in_last | input | 1 | Beat ends the message |
| in_bytes | input | 4 | Valid byte count of the last beat, 0 meaning 16 |
| crc_out | output | 32 | Reduced CRC of the latest message |
| crc_done | output | 1 | One-cycle pulse when `crc_out` is updated |

## Verification
The bench runs all tail lengths from 1 to 15 bytes. A wrong shift direction or wrong shift amount in the tail alignment would give a wrong CRC for those lengths while whole-block messages still pass. It drives random data into the lanes above the count, random `in_bytes` on full beats, and random seeds after the first beat. A missing mask, a count taken from the wrong beat, or a seed taken again on a later beat would therefore corrupt the result. Stalls between beats and back-to-back messages that start in the done cycle catch a fold that runs on idle cycles, or a first-beat flag that is not set again after a message ends. A message of all zeros with a zero seed must give zero, which exposes any stray constant left in the reduction steps.

// File: rtl/crc32r_fold.sv
module crc32r_fold #(
  parameter logic [32:0] K3 = 33'h1751997d0,
  parameter logic [32:0] K4 = 33'h0ccaa009e,
  parameter logic [32:0] K5 = 33'h163cd6124,
  parameter logic [32:0] MU = 33'h1f7011641,
  parameter logic [32:0] PP = 33'h1db710641
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  seed,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_data,
  input  logic         in_last,
  input  logic [3:0]   in_bytes,
  output logic [31:0]  crc_out,
  output logic         crc_done
);
  typedef enum logic [1:0] {S_TAKE, S_R96, S_R64, S_BAR} st_t;

  function automatic logic [95:0] clm64(input logic [63:0] a, input logic [32:0] b);
    logic [95:0] p;
    p = '0;
    for (int i = 0; i < 33; i++)
      if (b[i]) p = p ^ ({32'b0, a} << i);
    return p;
  endfunction

  function automatic logic [63:0] clm32(input logic [31:0] a, input logic [32:0] b);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < 33; i++)
      if (b[i]) p = p ^ ({32'b0, a} << i);
    return p;
  endfunction

  st_t          st;
  logic         first_q;
  logic [127:0] rem;

  logic [4:0]   nb;
  logic [7:0]   sh_hi, sh_lo;
  logic [127:0] din, a_blk, b_blk, folded;
  logic [95:0]  t96;
  logic [63:0]  u64;

  assign in_ready = (st == S_TAKE);
  assign nb     = (in_last && in_bytes != 4'd0) ? {1'b0, in_bytes} : 5'd16;
  assign sh_hi  = {5'd16 - nb, 3'b000};
  assign sh_lo  = {nb, 3'b000};
  assign din    = in_data & ({128{1'b1}} >> sh_hi);
  assign a_blk  = rem << sh_hi;
  assign b_blk  = (rem >> sh_lo) | (din << sh_hi);
  assign folded = {32'b0, clm64(a_blk[63:0], K3) ^ clm64(a_blk[127:64], K4)} ^ b_blk;
  assign t96    = clm64(rem[63:0], K4) ^ {32'b0, rem[127:64]};
  assign u64    = rem[95:32] ^ clm32(rem[31:0], K5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_TAKE;
      first_q  <= 1'b1;
      rem      <= '0;
      crc_out  <= '0;
      crc_done <= 1'b0;
    end else begin
      crc_done <= 1'b0;
      case (st)
        S_TAKE: if (in_valid) begin
          rem     <= first_q ? (din ^ {96'b0, seed}) : folded;
          first_q <= in_last;
          if (in_last) st <= S_R96;
        end
        S_R96: begin
          rem <= {32'b0, t96};
          st  <= S_R64;
        end
        S_R64: begin
          rem <= {64'b0, u64};
          st  <= S_BAR;
        end
        S_BAR: begin
          crc_out  <= rem[63:32] ^ 32'(clm32(32'(clm32(rem[31:0], MU)), PP) >> 32);
          crc_done <= 1'b1;
          st       <= S_TAKE;
        end
        default: st <= S_TAKE;
      endcase
    end
  end
endmodule

// File: rtl/crc32r_fold_chk.sv
module crc32r_fold_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_last,
  input logic [31:0] crc_out,
  input logic        crc_done
);
  // R5
  last_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready) && $past(!in_ready, 2)) |=> in_ready);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |=> !crc_done);

  // R6
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |-> in_ready);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_done |-> $stable(crc_out));
endmodule

bind crc32r_fold crc32r_fold_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .crc_out(crc_out), .crc_done(crc_done)
);

// File: tb/crc32r_fold_tb_top.sv
module crc32r_fold_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  seed = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         in_last = 1'b0;
  logic [3:0]   in_bytes = '0;
  logic [31:0]  crc_out;
  logic         crc_done;

  always #4 clk = ~clk;

  crc32r_fold dut_i (
    .clk(clk), .rst_n(rst_n), .seed(seed), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes),
    .crc_out(crc_out), .crc_done(crc_done)
  );

  int          total = 0;
  int          bad = 0;
  int          phase = 0;
  bit          exp_done = 1'b0;
  logic [31:0] exp_crc = '0;
  logic [7:0]  msg [0:255];

  function automatic logic [31:0] ref_crc(input logic [31:0] sd, input int n);
    logic [31:0] c;
    c = sd;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'b0, msg[i]};
      for (int b = 0; b < 8; b++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    bit hs;
    hs = in_valid && (phase == 0);
    @(posedge clk);
    exp_done = 1'b0;
    if (phase == 3) begin phase = 0; exp_done = 1'b1; end
    else if (phase != 0) phase++;
    else if (hs && in_last) phase = 1;
    @(negedge clk);
    chk(in_ready == (phase == 0), "R5", "in_ready", {31'b0, in_ready}, {31'b0, phase == 0});
    chk(crc_done == exp_done, "R6", "crc_done", {31'b0, crc_done}, {31'b0, exp_done});
    if (exp_done) chk(crc_out == exp_crc, tag, "crc_out", crc_out, exp_crc);
  endtask

  task automatic run_msg(input int len, input logic [31:0] sd, input int gap_pct, input string tag);
    int nbeat;
    int rb;
    exp_crc = ref_crc(sd, len);
    nbeat = (len + 15) / 16;
    for (int b = 0; b < nbeat; b++) begin
      while ($urandom_range(99) < gap_pct) begin
        in_valid = 1'b0;
        in_data  = {4{$urandom}};
        in_last  = 1'($urandom);
        in_bytes = 4'($urandom);
        seed     = $urandom;
        step(tag);
      end
      rb = len - 16 * b;
      in_valid = 1'b1;
      for (int j = 0; j < 16; j++)
        in_data[8*j +: 8] = (j < rb) ? msg[16*b + j] : 8'($urandom);
      in_last  = (b == nbeat - 1);
      in_bytes = in_last ? ((rb >= 16) ? 4'd0 : 4'(rb)) : 4'($urandom);
      seed     = (b == 0) ? sd : $urandom;
      step(tag);
    end
    in_valid = 1'b0;
    repeat (3) step(tag);
  endtask

  task automatic fill_rand(input int len);
    for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog: actual %0d expected %0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held in reset
    chk(in_ready == 1'b1, "R1", "in_ready in reset", {31'b0, in_ready}, 32'd1);
    chk(crc_done == 1'b0, "R1", "crc_done in reset", {31'b0, crc_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready", {31'b0, in_ready}, 32'd1);
    chk(crc_done == 1'b0, "R1", "crc_done", {31'b0, crc_done}, 32'd0);
    chk(crc_out == 32'd0, "R1", "crc_out", crc_out, 32'd0);

    // R2: zero message, zero seed gives zero
    for (int i = 0; i < 16; i++) msg[i] = 8'h00;
    run_msg(16, 32'h0, 0, "R2");
    // R2: single block, random seed
    fill_rand(16);
    run_msg(16, $urandom, 0, "R2");
    fill_rand(16);
    run_msg(16, 32'hFFFFFFFF, 0, "R2");

    // R3: whole-block messages, in_bytes random on full beats
    fill_rand(64);
    run_msg(32, $urandom, 0, "R3");
    fill_rand(64);
    run_msg(48, $urandom, 0, "R3");
    fill_rand(128);
    run_msg(128, $urandom, 0, "R3");

    // R4: every tail length, garbage above the count
    for (int t = 1; t < 16; t++) begin
      fill_rand(48);
      run_msg(16 + t, $urandom, 0, "R4");
    end
    fill_rand(48);
    run_msg(47, $urandom, 0, "R4");

    // R7: stalls between beats
    for (int k = 0; k < 4; k++) begin
      fill_rand(100);
      run_msg(64 + 9 * k, $urandom, 50, "R7");
    end

    // R8 R9: random lengths, garbage seed after first beat, back-to-back starts
    for (int k = 0; k < 40; k++) begin
      int len;
      len = $urandom_range(200, 16);
      fill_rand(len);
      run_msg(len, $urandom, 15, "R8 R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule